// File: doc/BRIEF.md
# Fractional N/N+1 Feedback Divider

This block divides a fast clock by a programmable ratio whose average lies between two integers. Every output cycle lasts either N or N+1 input clocks. A first-order phase accumulator picks the modulus for each cycle, so the mean ratio is N plus the fractional word divided by 2^FRAC_W. Because the ratio need not be a whole number, the synthesizer around it can run its comparison clock faster for the same output step. The modulus switches every few cycles, and this moves the phase at the comparator in a periodic pattern. Correcting that movement is the job of logic outside this block.

The block emits a one-clock pulse when each division cycle completes, and a flag that shows whether the current cycle uses N+1. New N and fraction values are captured on a load strobe and held in a staging register. They take effect only at the next cycle boundary, so a cycle that is already running is never cut short or stretched.

Top module: `fracn_divider`

## Requirements
- R1: While `rst` is high, `div_pulse` and `mod_plus` are low. After release, the staged ratio is N_RESET with fraction 0. The first pulse comes N_RESET-1 clocks after release, and every later cycle is N_RESET clocks long.
- R2: Each output cycle lasts N or N+1 input clocks. `div_pulse` is high for exactly one clock, the last clock of the cycle, so two pulses are never adjacent.
- R3: `mod_plus` is 1 for the whole of a cycle that lasts N+1 clocks and 0 for the whole of a cycle that lasts N clocks. It changes only on the clock edge that follows a pulse.
- R4: A FRAC_W-bit accumulator adds the fraction F once at each cycle boundary, and its carry selects N+1 for the cycle that starts there. Over any 2^FRAC_W consecutive cycles with a fixed (N, F), exactly F cycles use N+1, and the total is 2^FRAC_W*N + F input clocks.
- R5: With F = 0, every cycle lasts exactly N clocks and `mod_plus` stays 0.
- R6: A load captures `n_in` and `frac_in` and applies them at the first cycle boundary after the load. The cycle in progress keeps its old length.
- R7: A load with `n_in` below 2 is ignored as a whole: neither field changes, and the division continues with the previous values.
- R8: Every N from 2 up to 2^CNT_W-1 works, including a division by 2^CNT_W when the largest N is combined with an N+1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed input clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| n_in | input | CNT_W | Integer modulus N offered on a load |
| frac_in | input | FRAC_W | Fractional word F offered on a load |
| load | input | 1 | One-clock strobe that stages `n_in` and `frac_in` |
| div_pulse | output | 1 | High on the last input clock of each division cycle |
| mod_plus | output | 1 | High during a cycle that divides by N+1 |

## Verification
The assertions check, on every clock, the properties that hold locally in time:
- a pulse is one clock wide;
- the flag holds steady inside a cycle;
- each measured cycle length equals the active N plus the flag;
- a zero fraction never selects N+1;
- the active setting changes only at a boundary and never falls below 2.

Some behaviours span many cycles, and only the bench scenarios can show them:
- the exact count of N+1 cycles over a full accumulator period, together with the total clock count;
- the delay from a load to its effect;
- the rejection of a load with N below 2;
- the timing of the first pulse after reset.

// File: rtl/fracn_div_pkg.sv
package fracn_div_pkg;

    localparam int unsigned MIN_N       = 2;
    localparam int unsigned CNT_W_DEF   = 8;
    localparam int unsigned FRAC_W_DEF  = 4;
    localparam int unsigned N_RESET_DEF = 4;

    typedef enum logic {
        MOD_BASE = 1'b0,
        MOD_PLUS = 1'b1
    } mod_sel_e;

    function automatic logic n_is_legal(input logic [31:0] n);
        return n >= MIN_N;
    endfunction

    function automatic mod_sel_e sel_from_carry(input logic carry);
        return carry ? MOD_PLUS : MOD_BASE;
    endfunction

endpackage

// File: rtl/fracn_cfg_hold.sv
module fracn_cfg_hold
    import fracn_div_pkg::*;
#(
    parameter int unsigned NW    = CNT_W_DEF,
    parameter int unsigned FW    = FRAC_W_DEF,
    parameter int unsigned N_RST = N_RESET_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [NW-1:0] n_in,
    input  logic [FW-1:0] frac_in,
    input  logic          commit,
    output logic [NW-1:0] nxt_n,
    output logic [FW-1:0] nxt_frac,
    output logic [NW-1:0] act_n,
    output logic [FW-1:0] act_frac
);

    typedef struct packed {
        logic [NW-1:0] n;
        logic [FW-1:0] frac;
    } cfg_t;

    localparam cfg_t CFG_RST = '{n: NW'(N_RST), frac: '0};

    cfg_t stage_q;
    cfg_t live_q;
    cfg_t pick;
    logic pend_q;
    logic accept;

    assign accept = load && n_is_legal(32'(n_in));
    assign pick   = pend_q ? stage_q : live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= CFG_RST;
            live_q  <= CFG_RST;
            pend_q  <= 1'b0;
        end else begin
            if (commit) begin
                live_q <= pick;
            end
            if (accept) begin
                stage_q <= '{n: n_in, frac: frac_in};
                pend_q  <= 1'b1;
            end else if (commit) begin
                pend_q  <= 1'b0;
            end
        end
    end

    assign nxt_n    = pick.n;
    assign nxt_frac = pick.frac;
    assign act_n    = live_q.n;
    assign act_frac = live_q.frac;

endmodule

// File: rtl/fracn_accum.sv
module fracn_accum
    import fracn_div_pkg::*;
#(
    parameter int unsigned FW = FRAC_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [FW-1:0] frac,
    output mod_sel_e      sel
);

    localparam int unsigned SW = FW + 1;

    logic [FW-1:0] acc_q;
    logic [SW-1:0] sum;

    assign sum = {1'b0, acc_q} + {1'b0, frac};
    assign sel = sel_from_carry(sum[FW]);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum[FW-1:0];
        end
    end

endmodule

// File: rtl/fracn_modcnt.sv
module fracn_modcnt
    import fracn_div_pkg::*;
#(
    parameter int unsigned NW    = CNT_W_DEF,
    parameter int unsigned N_RST = N_RESET_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] next_n,
    input  mod_sel_e      next_sel,
    output logic          term,
    output mod_sel_e      cur_sel
);

    logic [NW-1:0] cnt_q;
    logic [NW-1:0] reload;

    // N >= 2 is guaranteed upstream, so N-1+sel never wraps.
    assign reload = next_n - NW'(1) + NW'(next_sel == MOD_PLUS);
    assign term   = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= NW'(N_RST - 1);
            cur_sel <= MOD_BASE;
        end else if (term) begin
            cnt_q   <= reload;
            cur_sel <= next_sel;
        end else begin
            cnt_q   <= cnt_q - NW'(1);
        end
    end

endmodule

// File: rtl/fracn_divider.sv
module fracn_divider
    import fracn_div_pkg::*;
#(
    parameter int unsigned CNT_W   = CNT_W_DEF,
    parameter int unsigned FRAC_W  = FRAC_W_DEF,
    parameter int unsigned N_RESET = N_RESET_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  n_in,
    input  logic [FRAC_W-1:0] frac_in,
    input  logic              load,
    output logic              div_pulse,
    output logic              mod_plus
);

    logic [CNT_W-1:0]  nxt_n;
    logic [FRAC_W-1:0] nxt_frac;
    logic [CNT_W-1:0]  act_n;
    logic [FRAC_W-1:0] act_frac;
    logic              term;
    mod_sel_e          nxt_sel;
    mod_sel_e          cur_sel;

    fracn_cfg_hold #(
        .NW    (CNT_W),
        .FW    (FRAC_W),
        .N_RST (N_RESET)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .n_in     (n_in),
        .frac_in  (frac_in),
        .commit   (term),
        .nxt_n    (nxt_n),
        .nxt_frac (nxt_frac),
        .act_n    (act_n),
        .act_frac (act_frac)
    );

    fracn_accum #(
        .FW (FRAC_W)
    ) u_acc (
        .clk  (clk),
        .rst  (rst),
        .step (term),
        .frac (nxt_frac),
        .sel  (nxt_sel)
    );

    fracn_modcnt #(
        .NW    (CNT_W),
        .N_RST (N_RESET)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .next_n   (nxt_n),
        .next_sel (nxt_sel),
        .term     (term),
        .cur_sel  (cur_sel)
    );

    assign div_pulse = term;
    assign mod_plus  = (cur_sel == MOD_PLUS);

endmodule

// File: rtl/fracn_divider_chk.sv
module fracn_divider_chk #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned FRAC_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              div_pulse,
    input logic              mod_plus,
    input logic [CNT_W-1:0]  act_n,
    input logic [FRAC_W-1:0] act_frac
);

    logic [CNT_W:0] gap_q;
    logic           seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (div_pulse) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !div_pulse |=> $stable(mod_plus));

    // R2
    period_len_chk: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && seen_q) |->
        ((gap_q + 1'b1) == ({1'b0, act_n} + {{CNT_W{1'b0}}, mod_plus})));

    // R5
    zero_frac_chk: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && act_frac == '0) |-> !mod_plus);

    // R6
    cfg_steady_chk: assert property (@(posedge clk) disable iff (rst)
        !div_pulse |=> ($stable(act_n) && $stable(act_frac)));

    // R7
    min_n_chk: assert property (@(posedge clk) disable iff (rst)
        act_n >= CNT_W'(2));

endmodule

bind fracn_divider fracn_divider_chk #(
    .CNT_W  (CNT_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .div_pulse (div_pulse),
    .mod_plus  (mod_plus),
    .act_n     (act_n),
    .act_frac  (act_frac)
);

// File: tb/fracn_divider_tb.sv
`timescale 1ns/1ps
module fracn_divider_tb;

    localparam int CNT_W   = 8;
    localparam int FRAC_W  = 4;
    localparam int N_RESET = 4;
    localparam int PERIODS = 1 << FRAC_W;
    localparam int NVEC    = 8;
    localparam int WD_MAX  = 150000;

    localparam logic [CNT_W-1:0]  VEC_N [NVEC] = '{8'd2, 8'd2, 8'd5, 8'd7, 8'd10, 8'd3, 8'd255, 8'd16};
    localparam logic [FRAC_W-1:0] VEC_F [NVEC] = '{4'd0, 4'd15, 4'd3, 4'd8, 4'd1, 4'd15, 4'd7, 4'd0};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CNT_W-1:0]  n_in = '0;
    logic [FRAC_W-1:0] frac_in = '0;
    logic              load = 1'b0;
    logic              div_pulse;
    logic              mod_plus;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    fracn_divider #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .N_RESET(N_RESET)) u_dut (
        .clk(clk), .rst(rst), .n_in(n_in), .frac_in(frac_in),
        .load(load), .div_pulse(div_pulse), .mod_plus(mod_plus)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cycles++;
    endtask

    task automatic wait_pulse(output int len);
        len = 0;
        do begin
            tick();
            len++;
        end while (!div_pulse && len < 1000);
    endtask

    // Called with the last sample on a pulse; the next cycle begins with the staged setting.
    task automatic measure(input string req, input int n, input int f);
        int plus_cnt = 0;
        int total = 0;
        int bad_len = 0;
        int len;
        for (int i = 0; i < PERIODS; i++) begin
            wait_pulse(len);
            if (len != n + int'(mod_plus)) bad_len++;
            plus_cnt += int'(mod_plus);
            total += len;
        end
        check({req, " R2 cycle length N or N+1"}, bad_len, 0);
        check({req, " R4 count of N+1 cycles"}, plus_cnt, f);
        check({req, " R4 total input clocks"}, total, n * PERIODS + f);
    endtask

    // Stages a setting one clock after a pulse, so the load lands inside a running cycle.
    task automatic apply(input int n, input int f, output int cur_len);
        int len;
        wait_pulse(len);
        tick();
        n_in = CNT_W'(n);
        frac_in = FRAC_W'(f);
        load = 1'b1;
        tick();
        load = 1'b0;
        wait_pulse(len);
        cur_len = len + 2;
    endtask

    initial begin
        int len;
        // R1: reset state
        repeat (3) tick();
        check("R1 pulse low in reset", int'(div_pulse), 0);
        check("R1 flag low in reset", int'(mod_plus), 0);
        rst = 1'b0;
        wait_pulse(len);
        check("R1 first pulse delay", len, N_RESET - 1);
        wait_pulse(len);
        check("R1 reset ratio period", len, N_RESET);
        check("R5 reset fraction gives N", int'(mod_plus), 0);

        // R4 R5 R8: table of settings
        for (int v = 0; v < NVEC; v++) begin
            apply(int'(VEC_N[v]), int'(VEC_F[v]), len);
            measure($sformatf("vec%0d", v), int'(VEC_N[v]), int'(VEC_F[v]));
        end

        // R6: a load does not change the running cycle
        apply(10, 0, len);
        measure("R6 setup", 10, 0);
        apply(3, 0, len);
        check("R6 running cycle keeps old length", len, 10);
        wait_pulse(len);
        check("R6 new length after boundary", len, 3);

        // R7: loads with N below 2 are ignored
        apply(5, 0, len);
        measure("R7 setup", 5, 0);
        apply(1, 9, len);
        measure("R7 n=1 ignored", 5, 0);
        apply(0, 15, len);
        measure("R7 n=0 ignored", 5, 0);

        // R3: flag stays constant through each cycle
        apply(6, 5, len);
        wait_pulse(len);
        begin
            int changes = 0;
            int prev = int'(mod_plus);
            for (int i = 0; i < 200; i++) begin
                bit was_pulse = div_pulse;
                tick();
                if (!was_pulse && int'(mod_plus) != prev) changes++;
                prev = int'(mod_plus);
            end
            check("R3 flag changes only after a pulse", changes, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > WD_MAX);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WD_MAX);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule